// File: doc/BRIEF.md
# Privilege stack trap controller

This block keeps the machine status word of a processor hart. Inside that word is a three-entry stack, and each entry pairs a privilege level with an interrupt-enable bit. Entry 0 holds the level the hart is running at now. Entries 1 and 2 hold the levels to go back to.

When the pipeline raises a trap strobe, the block does four things. It pushes the stack. It drops the hart into machine level with interrupts off. It latches the trap cause and the faulting PC. It sends the fetch unit to a vector whose offset grows with the level the hart was at when the trap arrived. When the pipeline raises a return strobe, the block pops the stack and sends fetch back to the saved exception PC.

Software reaches the state through a 12-bit CSR access port. A write to the status word is filtered field by field, so an illegal privilege code or address-translation mode leaves that field as it was. An access to an address the block does not decode raises an illegal-access flag. Trap, return and CSR accesses are single-cycle control strobes, so the block has no back-pressure. The next PC is updated in the cycle after a trap or return, and `redirect_o` pulses high for that one cycle.

Top module: `priv_trap_ctrl`

## Requirements
- R1: Privilege codes are user=0, supervisor=1, machine=3. The code 2 is reserved. A status write that carries 2 in any of the three level fields leaves that field unchanged, and the other fields still take the written value.
- R2: After reset, level 0 is machine and levels 1 and 2 are supervisor. Every other status field is 0, the saved PC and cause are 0, `pc_o` equals the vector base plus 0x100, and `redirect_o` is low.
- R3: The status word (CSR address 0x300, also on `status_o`) has this layout. Level 0 privilege is at [1:0], level 1 at [3:2] and level 2 at [5:4]. The enables for levels 0, 1 and 2 are at bits 6, 7 and 8. Modify-privilege is bit 9, FP state is [11:10], extension state is [13:12], translation mode is [18:14], and the summary-dirty bit is at XLEN-1. All other bits read 0.
- R4: On a trap, level 2 takes level 1's privilege and enable, and level 1 takes level 0's. Level 0 then becomes machine with its enable cleared, and modify-privilege is cleared.
- R5: The cycle after a trap, `pc_o` equals the vector base plus 0x40 times the level-0 privilege held before the trap, and `redirect_o` is high for exactly that cycle.
- R6: On a return, level 0 takes level 1's privilege and enable, and level 1 takes level 2's. Level 2 becomes user with its enable set. In the next cycle `pc_o` equals the saved exception PC and `redirect_o` is high.
- R7: A trap stores its cause input in the cause register (address 0x342) and its PC input in the exception-PC register (address 0x341).
- R8: In the 64-bit configuration, the translation-mode field accepts only bare (0), 39-bit paged (9) and 48-bit paged (10). In the 32-bit configuration it accepts only bare (0) and 32-bit paged (8). Any other written value leaves the field unchanged.
- R9: The summary-dirty bit reads 1 exactly when the FP-state field or the extension-state field is 3. Writing to that bit has no effect.
- R10: `csr_illegal_o` is high in the same cycle as an access (`csr_en_i`) to any address other than 0x300, 0x341 or 0x342. Such a write changes no state.
- R11: When trap and return arrive together, only the trap takes effect. A CSR write in a cycle with a trap or a return is dropped.
- R12: The enable, modify-privilege, FP-state and extension-state fields take the written value directly. The exception-PC and cause registers take any written value in full. A return uses the current exception-PC value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_i | input | 1 | Trap strobe, one cycle per trap |
| trap_cause_i | input | XLEN | Cause recorded on a trap |
| trap_epc_i | input | XLEN | Faulting PC recorded on a trap |
| ret_i | input | 1 | Return-from-trap strobe |
| csr_en_i | input | 1 | CSR access strobe |
| csr_we_i | input | 1 | CSR access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data for the addressed register |
| csr_illegal_o | output | 1 | Access to an undecoded address |
| pc_o | output | XLEN | Next fetch PC |
| redirect_o | output | 1 | `pc_o` was updated by a trap or return last edge |
| priv_o | output | 2 | Current privilege level |
| ie_o | output | 1 | Current global interrupt enable |
| status_o | output | XLEN | Status word as software reads it |

## Verification
The properties assume that every strobe is sampled as a known value at each rising edge. They place no limit on how trap, return and CSR accesses overlap, because the block resolves any overlap by its fixed priority. The stimulus drives all inputs on the falling edge. It mixes directed sequences with a long random run in which traps and returns sometimes coincide, write data often carries the reserved privilege code or an unsupported translation mode, and addresses are drawn from a set that includes undecoded ones.

// File: rtl/psc_pkg.sv
package psc_pkg;

  localparam logic [1:0] LVL_USER  = 2'd0;
  localparam logic [1:0] LVL_SUPER = 2'd1;
  localparam logic [1:0] LVL_RSVD  = 2'd2;
  localparam logic [1:0] LVL_MACH  = 2'd3;

  localparam logic [4:0] XM_BARE = 5'd0;
  localparam logic [4:0] XM_PG32 = 5'd8;
  localparam logic [4:0] XM_PG39 = 5'd9;
  localparam logic [4:0] XM_PG48 = 5'd10;

  localparam logic [11:0] ADDR_STAT  = 12'h300;
  localparam logic [11:0] ADDR_EPC   = 12'h341;
  localparam logic [11:0] ADDR_CAUSE = 12'h342;

  localparam int LEVELS    = 3;
  localparam int VEC_SHIFT = 6;
  localparam int RESET_OFS = 'h100;

  // stack entries: lvl[k] privilege, en[k] interrupt enable, entry 0 is live
  typedef struct packed {
    logic [4:0]              xmode;
    logic [1:0]              xst;
    logic [1:0]              fst;
    logic                    mprv;
    logic [LEVELS-1:0]       en;
    logic [LEVELS-1:0][1:0]  lvl;
  } stat_t;

  localparam int STAT_BITS = $bits(stat_t);

  function automatic logic lvl_ok(input logic [1:0] l);
    return l != LVL_RSVD;
  endfunction

endpackage

// File: rtl/psc_wr_filter.sv
module psc_wr_filter
  import psc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  stat_t            cur_i,
  input  logic [XLEN-1:0]  wdata_i,
  output stat_t            nxt_o
);

  stat_t req;
  logic  xm_ok;
  logic  unused_hi;

  assign req       = stat_t'(wdata_i[STAT_BITS-1:0]);
  assign unused_hi = ^wdata_i[XLEN-1:STAT_BITS];

  generate
    if (XLEN == 64) begin : g_xm64
      assign xm_ok = (req.xmode == XM_BARE) || (req.xmode == XM_PG39) ||
                     (req.xmode == XM_PG48);
    end else begin : g_xm32
      assign xm_ok = (req.xmode == XM_BARE) || (req.xmode == XM_PG32);
    end
  endgenerate

  always_comb begin
    nxt_o = req;
    for (int k = 0; k < LEVELS; k++) begin
      if (!lvl_ok(req.lvl[k])) nxt_o.lvl[k] = cur_i.lvl[k];
    end
    if (!xm_ok) nxt_o.xmode = cur_i.xmode;
  end

endmodule

// File: rtl/psc_stack.sv
module psc_stack
  import psc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_i,
  input  logic  pop_i,
  input  logic  load_i,
  input  stat_t load_val_i,
  output stat_t q_o
);

  localparam stat_t STAT_RST = '{xmode: XM_BARE, xst: 2'd0, fst: 2'd0, mprv: 1'b0,
                                 en: '0, lvl: {LVL_SUPER, LVL_SUPER, LVL_MACH}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= STAT_RST;
    end else if (push_i) begin
      q_o.lvl  <= {q_o.lvl[1], q_o.lvl[0], LVL_MACH};
      q_o.en   <= {q_o.en[1], q_o.en[0], 1'b0};
      q_o.mprv <= 1'b0;
    end else if (pop_i) begin
      q_o.lvl <= {LVL_USER, q_o.lvl[2], q_o.lvl[1]};
      q_o.en  <= {1'b1, q_o.en[2], q_o.en[1]};
    end else if (load_i) begin
      q_o <= load_val_i;
    end
  end

endmodule

// File: rtl/psc_vector.sv
module psc_vector
  import psc_pkg::*;
#(
  parameter int          XLEN      = 64,
  parameter logic [63:0] TVEC_BASE = 64'h2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_i,
  input  logic            ret_i,
  input  logic [1:0]      lvl_i,
  input  logic [XLEN-1:0] epc_i,
  output logic [XLEN-1:0] pc_o,
  output logic            redirect_o
);

  localparam logic [XLEN-1:0] BASE_V = TVEC_BASE[XLEN-1:0];
  localparam logic [XLEN-1:0] RST_PC = BASE_V + XLEN'(RESET_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o       <= RST_PC;
      redirect_o <= 1'b0;
    end else begin
      redirect_o <= trap_i | ret_i;
      if (trap_i)     pc_o <= BASE_V + (XLEN'(lvl_i) << VEC_SHIFT);
      else if (ret_i) pc_o <= epc_i;
    end
  end

endmodule

// File: rtl/psc_csr_regs.sv
module psc_csr_regs
  import psc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic            acc_en_i,
  input  logic            acc_we_i,
  input  logic            blocked_i,
  input  logic [11:0]     addr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] status_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            illegal_o,
  output logic            stat_wr_o,
  output logic [XLEN-1:0] epc_o
);

  logic            hit_stat, hit_epc, hit_cause, wr_ok;
  logic [XLEN-1:0] cause_q;

  assign hit_stat  = addr_i == ADDR_STAT;
  assign hit_epc   = addr_i == ADDR_EPC;
  assign hit_cause = addr_i == ADDR_CAUSE;
  assign illegal_o = acc_en_i & ~(hit_stat | hit_epc | hit_cause);
  assign wr_ok     = acc_en_i & acc_we_i & ~blocked_i;
  assign stat_wr_o = wr_ok & hit_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_o   <= '0;
      cause_q <= '0;
    end else if (trap_i) begin
      epc_o   <= epc_i;
      cause_q <= cause_i;
    end else if (wr_ok && hit_epc) begin
      epc_o <= wdata_i;
    end else if (wr_ok && hit_cause) begin
      cause_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_stat)       rdata_o = status_i;
    else if (hit_epc)   rdata_o = epc_o;
    else if (hit_cause) rdata_o = cause_q;
  end

endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
  import psc_pkg::*;
#(
  parameter int          XLEN      = 64,
  parameter logic [63:0] TVEC_BASE = 64'h2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic [XLEN-1:0] trap_epc_i,
  input  logic            ret_i,
  input  logic            csr_en_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_illegal_o,
  output logic [XLEN-1:0] pc_o,
  output logic            redirect_o,
  output logic [1:0]      priv_o,
  output logic            ie_o,
  output logic [XLEN-1:0] status_o
);

  localparam int PAD_BITS = XLEN - 1 - STAT_BITS;

  stat_t           stat_q, stat_nxt;
  logic            stat_wr, sd, blocked;
  logic [XLEN-1:0] epc_q;

  assign blocked  = trap_i | ret_i;
  assign sd       = (stat_q.fst == 2'b11) || (stat_q.xst == 2'b11);
  assign status_o = {sd, {PAD_BITS{1'b0}}, stat_q};
  assign priv_o   = stat_q.lvl[0];
  assign ie_o     = stat_q.en[0];

  psc_csr_regs #(.XLEN(XLEN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_i    (trap_i),
    .cause_i   (trap_cause_i),
    .epc_i     (trap_epc_i),
    .acc_en_i  (csr_en_i),
    .acc_we_i  (csr_we_i),
    .blocked_i (blocked),
    .addr_i    (csr_addr_i),
    .wdata_i   (csr_wdata_i),
    .status_i  (status_o),
    .rdata_o   (csr_rdata_o),
    .illegal_o (csr_illegal_o),
    .stat_wr_o (stat_wr),
    .epc_o     (epc_q)
  );

  psc_wr_filter #(.XLEN(XLEN)) u_filter (
    .cur_i   (stat_q),
    .wdata_i (csr_wdata_i),
    .nxt_o   (stat_nxt)
  );

  psc_stack u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (trap_i),
    .pop_i      (ret_i & ~trap_i),
    .load_i     (stat_wr),
    .load_val_i (stat_nxt),
    .q_o        (stat_q)
  );

  psc_vector #(.XLEN(XLEN), .TVEC_BASE(TVEC_BASE)) u_vector (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_i     (trap_i),
    .ret_i      (ret_i),
    .lvl_i      (stat_q.lvl[0]),
    .epc_i      (epc_q),
    .pc_o       (pc_o),
    .redirect_o (redirect_o)
  );

endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int          XLEN      = 64,
  parameter logic [63:0] TVEC_BASE = 64'h2000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_i,
  input logic            ret_i,
  input logic            csr_illegal_o,
  input logic [XLEN-1:0] pc_o,
  input logic            redirect_o,
  input logic [1:0]      priv_o,
  input logic            ie_o,
  input logic [XLEN-1:0] status_o
);

  localparam logic [XLEN-1:0] BASE_V = TVEC_BASE[XLEN-1:0];

  assert_trap_enters_mach_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (priv_o == 2'd3) && !ie_o);

  assert_trap_pushes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (status_o[3:2] == $past(priv_o)) && (status_o[7] == $past(ie_o)) &&
               (status_o[5:4] == $past(status_o[3:2])) && (status_o[8] == $past(status_o[7])));

  assert_trap_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> pc_o == BASE_V + (XLEN'($past(priv_o)) << 6));

  assert_redirect_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i || ret_i) |=> redirect_o);

  assert_return_pops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !trap_i) |=> (priv_o == $past(status_o[3:2])) && (ie_o == $past(status_o[7])) &&
                           (status_o[5:4] == 2'd0) && status_o[8]);

  assert_no_rsvd_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_o != 2'd2) && (status_o[3:2] != 2'd2) && (status_o[5:4] != 2'd2));

  assert_illegal_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_illegal_o && !trap_i && !ret_i) |=> $stable(status_o));

  assert_trap_beats_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && ret_i) |=> (priv_o == 2'd3) && (status_o[3:2] == $past(priv_o)));

endmodule

bind priv_trap_ctrl psc_checker #(.XLEN(XLEN), .TVEC_BASE(TVEC_BASE)) u_psc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .trap_i        (trap_i),
  .ret_i         (ret_i),
  .csr_illegal_o (csr_illegal_o),
  .pc_o          (pc_o),
  .redirect_o    (redirect_o),
  .priv_o        (priv_o),
  .ie_o          (ie_o),
  .status_o      (status_o)
);

// File: tb/test_priv_trap_ctrl.sv
`timescale 1ns/1ps
module test_priv_trap_ctrl;

  localparam int          XLEN = 64;
  localparam logic [63:0] BASE = 64'h2000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trap_i = 1'b0, ret_i = 1'b0, csr_en_i = 1'b0, csr_we_i = 1'b0;
  logic [XLEN-1:0] trap_cause_i = '0, trap_epc_i = '0, csr_wdata_i = '0;
  logic [11:0]     csr_addr_i = '0;
  logic [XLEN-1:0] csr_rdata_o, pc_o, status_o;
  logic            csr_illegal_o, redirect_o, ie_o;
  logic [1:0]      priv_o;

  always #4 clk = ~clk;

  priv_trap_ctrl #(.XLEN(XLEN), .TVEC_BASE(BASE)) i_priv_trap_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .trap_cause_i(trap_cause_i),
    .trap_epc_i(trap_epc_i), .ret_i(ret_i), .csr_en_i(csr_en_i), .csr_we_i(csr_we_i),
    .csr_addr_i(csr_addr_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
    .csr_illegal_o(csr_illegal_o), .pc_o(pc_o), .redirect_o(redirect_o),
    .priv_o(priv_o), .ie_o(ie_o), .status_o(status_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int          m_lvl[3], m_en[3];
  int          m_mprv, m_fs, m_xs, m_vm, m_redir;
  logic [63:0] m_epc, m_cause, m_pc;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_status();
    logic [63:0] v = '0;
    for (int k = 0; k < 3; k++) begin
      v[2*k +: 2] = m_lvl[k][1:0];
      v[6+k]      = m_en[k][0];
    end
    v[9]     = m_mprv[0];
    v[11:10] = m_fs[1:0];
    v[13:12] = m_xs[1:0];
    v[18:14] = m_vm[4:0];
    v[63]    = (m_fs == 3) || (m_xs == 3);
    return v;
  endfunction

  function automatic logic [63:0] exp_read(input logic [11:0] a);
    if (a == 12'h300) return exp_status();
    if (a == 12'h341) return m_epc;
    if (a == 12'h342) return m_cause;
    return 64'd0;
  endfunction

  function automatic logic [63:0] wd(input int l0, l1, l2, e0, e1, e2, mp, fs, xs, vm);
    logic [63:0] v = '0;
    v[1:0] = l0[1:0]; v[3:2] = l1[1:0]; v[5:4] = l2[1:0];
    v[6] = e0[0]; v[7] = e1[0]; v[8] = e2[0]; v[9] = mp[0];
    v[11:10] = fs[1:0]; v[13:12] = xs[1:0]; v[18:14] = vm[4:0];
    return v;
  endfunction

  task automatic model_reset();
    m_lvl[0] = 3; m_lvl[1] = 1; m_lvl[2] = 1;
    m_en[0] = 0; m_en[1] = 0; m_en[2] = 0;
    m_mprv = 0; m_fs = 0; m_xs = 0; m_vm = 0; m_redir = 0;
    m_epc = 0; m_cause = 0; m_pc = BASE + 64'h100;
  endtask

  task automatic model_step(input logic t, r, en, we, input logic [11:0] a,
                            input logic [63:0] cause, epc, wdat);
    int v;
    m_redir = (t || r) ? 1 : 0;
    if (t) begin
      m_pc = BASE + 64'(m_lvl[0] * 64);
      m_lvl[2] = m_lvl[1]; m_en[2] = m_en[1];
      m_lvl[1] = m_lvl[0]; m_en[1] = m_en[0];
      m_lvl[0] = 3; m_en[0] = 0; m_mprv = 0;
      m_cause = cause; m_epc = epc;
    end else if (r) begin
      m_pc = m_epc;
      m_lvl[0] = m_lvl[1]; m_en[0] = m_en[1];
      m_lvl[1] = m_lvl[2]; m_en[1] = m_en[2];
      m_lvl[2] = 0; m_en[2] = 1;
    end else if (en && we) begin
      if (a == 12'h341) m_epc = wdat;
      else if (a == 12'h342) m_cause = wdat;
      else if (a == 12'h300) begin
        for (int k = 0; k < 3; k++) begin
          v = int'(wdat[2*k +: 2]);
          if (v != 2) m_lvl[k] = v;
          m_en[k] = int'(wdat[6+k]);
        end
        m_mprv = int'(wdat[9]);
        m_fs = int'(wdat[11:10]);
        m_xs = int'(wdat[13:12]);
        v = int'(wdat[18:14]);
        if (v == 0 || v == 9 || v == 10) m_vm = v;
      end
    end
  endtask

  // one clock: drive, check combinational outputs, advance model, compare
  task automatic cyc(input logic t, r, en, we, input logic [11:0] a,
                     input logic [63:0] cause, epc, wdat);
    logic ill;
    trap_i = t; ret_i = r; csr_en_i = en; csr_we_i = we; csr_addr_i = a;
    trap_cause_i = cause; trap_epc_i = epc; csr_wdata_i = wdat;
    #1;
    ill = en && !(a == 12'h300 || a == 12'h341 || a == 12'h342);
    chk("R10 illegal flag", 64'(csr_illegal_o), 64'(ill));
    if (en && !ill) chk("R3 read data", csr_rdata_o, exp_read(a));
    @(posedge clk);
    model_step(t, r, en, we, a, cause, epc, wdat);
    @(negedge clk);
    chk("R3 status word", status_o, exp_status());
    chk("R5 next pc", pc_o, m_pc);
    chk("R4 priv", 64'(priv_o), 64'(m_lvl[0]));
    chk("R4 ie", 64'(ie_o), 64'(m_en[0]));
    chk("R5 redirect", 64'(redirect_o), 64'(m_redir));
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 12'h0, 0, 0, 0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    cyc(0, 0, 1, 1, a, 0, 0, d);
  endtask

  task automatic rd(input logic [11:0] a);
    cyc(0, 0, 1, 0, a, 0, 0, 0);
  endtask

  logic [63:0] snap;

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R2 reset status", status_o, 64'h17);
    chk("R2 reset pc", pc_o, BASE + 64'h100);
    chk("R2 reset priv", 64'(priv_o), 64'd3);
    chk("R2 reset redirect", 64'(redirect_o), 64'd0);
    @(negedge clk);
    rd(12'h341);
    rd(12'h342);

    // trap from machine level
    cyc(1, 0, 0, 0, 12'h0, 64'd5, 64'h1234, 0);
    chk("R5 vector from M", pc_o, 64'h20C0);
    chk("R4 level1 holds M", 64'(status_o[3:2]), 64'd3);
    rd(12'h342);
    chk("R7 cause", csr_rdata_o, 64'd5);
    rd(12'h341);
    chk("R7 epc", csr_rdata_o, 64'h1234);

    // drop to user, trap again
    wr(12'h300, wd(0, 1, 3, 1, 1, 0, 1, 0, 0, 0));
    chk("R12 enable and priv written", 64'(ie_o), 64'd1);
    cyc(1, 0, 0, 0, 12'h0, 64'd7, 64'h2468, 0);
    chk("R5 vector from U", pc_o, 64'h2000);
    chk("R4 mprv cleared", 64'(status_o[9]), 64'd0);
    idle();
    chk("R5 redirect single cycle", 64'(redirect_o), 64'd0);

    // return
    cyc(0, 1, 0, 0, 12'h0, 0, 0, 0);
    chk("R6 return pc", pc_o, 64'h2468);
    chk("R6 return priv", 64'(priv_o), 64'd0);
    chk("R6 level2 user", 64'(status_o[5:4]), 64'd0);
    chk("R6 level2 enable", 64'(status_o[8]), 64'd1);

    // reserved level code
    wr(12'h300, wd(2, 2, 3, 1, 0, 0, 0, 0, 0, 0));
    chk("R1 level0 kept", 64'(priv_o), 64'd0);
    chk("R1 level1 kept", 64'(status_o[3:2]), 64'd1);
    chk("R1 level2 written", 64'(status_o[5:4]), 64'd3);

    // translation mode legality
    wr(12'h300, wd(0, 1, 3, 1, 0, 0, 0, 0, 0, 9));
    chk("R8 mode 9 taken", 64'(status_o[18:14]), 64'd9);
    wr(12'h300, wd(0, 1, 3, 1, 0, 0, 0, 0, 0, 8));
    chk("R8 mode 8 refused", 64'(status_o[18:14]), 64'd9);
    wr(12'h300, wd(0, 1, 3, 1, 0, 0, 0, 0, 0, 10));
    chk("R8 mode 10 taken", 64'(status_o[18:14]), 64'd10);
    wr(12'h300, wd(0, 1, 3, 1, 0, 0, 0, 0, 0, 31));
    chk("R8 mode 31 refused", 64'(status_o[18:14]), 64'd10);

    // summary dirty
    wr(12'h300, wd(0, 1, 3, 1, 0, 0, 0, 3, 0, 0));
    chk("R9 sd from fp", 64'(status_o[63]), 64'd1);
    wr(12'h300, wd(0, 1, 3, 1, 0, 0, 0, 1, 3, 0));
    chk("R9 sd from ext", 64'(status_o[63]), 64'd1);
    wr(12'h300, wd(0, 1, 3, 1, 0, 0, 0, 2, 1, 0) | 64'h8000_0000_0000_0000);
    chk("R9 sd read only", 64'(status_o[63]), 64'd0);

    // undecoded address
    snap = status_o;
    wr(12'h305, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R10 no state change", status_o, snap);

    // priority
    cyc(1, 1, 0, 0, 12'h0, 64'd9, 64'h7000, 0);
    chk("R11 trap beats return priv", 64'(priv_o), 64'd3);
    chk("R11 trap beats return pc", pc_o, 64'h2000);
    cyc(1, 0, 1, 1, 12'h300, 64'd9, 64'h7000, wd(1, 1, 1, 1, 1, 1, 0, 0, 0, 0));
    chk("R11 write dropped on trap", 64'(priv_o), 64'd3);
    cyc(0, 1, 1, 1, 12'h341, 0, 0, 64'h9999);
    chk("R11 epc write dropped on return", pc_o, 64'h7000);

    // software-set return address
    wr(12'h341, 64'h5550);
    wr(12'h342, 64'hDEAD_0000_0000_0001);
    rd(12'h342);
    chk("R12 cause written", csr_rdata_o, 64'hDEAD_0000_0000_0001);
    cyc(0, 1, 0, 0, 12'h0, 0, 0, 0);
    chk("R12 return to written epc", pc_o, 64'h5550);

    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic t, r, en, we;
      logic [11:0] a;
      logic [63:0] d;
      t  = ($urandom % 7) == 0;
      r  = ($urandom % 6) == 0;
      en = ($urandom % 2) == 0;
      we = ($urandom % 3) != 0;
      case ($urandom % 5)
        0: a = 12'h300;
        1: a = 12'h300;
        2: a = 12'h341;
        3: a = 12'h342;
        default: a = 12'(12'h300 + ($urandom % 64));
      endcase
      d = {$urandom, $urandom};
      if (($urandom % 2) == 0) d[18:14] = 5'(($urandom % 4) + 8);
      cyc(t, r, en, we, a, {$urandom, $urandom}, {$urandom, $urandom}, d);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule